// File: doc/BRIEF.md
# I2C Channel-Select Control Register

This block is the digital control side of a two-channel bus switch. It is an I2C slave clocked by a system clock. It brings SCL and SDA into that clock domain, finds START and STOP conditions, and compares the incoming address with a 7-bit address. That address is a fixed 5-bit prefix, chosen by a parameter, followed by two strap pins. Bytes written to it go into an 8-bit control register. The two lowest bits of that register select which downstream channels are connected.

A new selection stays pending until the bus shows a STOP. Only then does it move to the channel-enable outputs, so a channel is never connected in the middle of a transfer. A read returns the current selection together with the two interrupt levels delivered by a neighbouring filter block. The interrupt levels are taken at the moment the read byte is loaded for shifting. The SDA pin is driven only through an open-drain pull-low enable.

Top module: `chsel_i2c_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register and both `chan_en` bits clear to 0, `sda_oe` is 0 and the bus engine returns to idle. A read after reset returns 0 in bits 1:0.
- R2: The device answers only to address {prefix, `addr_strap[1]`, `addr_strap[0]`}, sent MSB first and followed by an R/W bit (1 = read). The prefix is 11100 for variant 0, 11110 for variant 1 and 01100 for variant 2. On any other address it gives no acknowledge and ignores the bus until the next START.
- R3: In a write, the address and every data byte are acknowledged by pulling SDA low on the ninth clock. When several data bytes arrive, only the last one remains in the register.
- R4: The `chan_en` outputs change only in response to a STOP. A written selection has no effect on `chan_en` before the STOP, and the STOP copies register bits 1:0 into `chan_en`. Bit 0 drives channel 0 and bit 1 drives channel 1.
- R5: Every selection value is legal: none, either channel alone, or both channels.
- R6: A read byte carries `irq_pend[0]` (1 = pending) in bit 4, `irq_pend[1]` in bit 5 and the register selection in bits 1:0. Bits 7:6 and 3:2 read as 0. Write data in bits 7:2 is discarded.
- R7: The interrupt bits of a read byte are the `irq_pend` values at the moment that byte is loaded. A later change appears only in the next byte.
- R8: After the master acknowledges a read byte, the next byte is sent. After a not-acknowledge, the slave releases SDA and stays released until the STOP.
- R9: A repeated START at any point restarts address reception. A partial address is discarded.
- R10: A reset in the middle of a write transaction discards the pending selection, and `chan_en` goes to 0.
- R11: `sda_oe` changes only while the SCL input is low, and SDA is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| addr_strap | input | 2 | Strap pins forming the two address LSBs |
| irq_pend | input | 2 | Filtered interrupt levels per channel, 1 = pending |
| chan_en | output | 2 | Channel connect enables, bit n for channel n |
| sda_oe | output | 1 | Pull-low enable for the SDA pad |

## Verification
The hardest case to reach is the exact moment the interrupt bits are captured. A read byte must hold the interrupt levels from its load instant, even though the bit is shifted out many clocks later. The stimulus reaches this through a multi-byte read. The master acknowledges the first byte, and the bench changes `irq_pend` only after the falling edge that loads the second byte. It then expects the old value in byte two and the new value in byte three. The STOP-gated channel switch is followed on every clock by a reference model that delays its own expectation by the synchronizer latency. A repeated START between a write and a read shows the register contents differing from the still-unchanged `chan_en`.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 7;
  localparam int IRQ_LSB  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RD_ACK_WAIT,
    ST_RD_ACK,
    ST_RD_LOAD
  } slv_state_t;

  function automatic logic [4:0] addr_prefix(input int variant);
    case (variant)
      1:       return 5'b11110;
      2:       return 5'b01100;
      default: return 5'b11100;
    endcase
  endfunction

endpackage

// File: rtl/chsel_line_sync.sv
module chsel_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_d;
  logic                   sda_d;
  logic                   scl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe[0] <= 1'b1;
      sda_pipe[0] <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_in;
      sda_pipe[0] <= sda_in;
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else begin
        scl_pipe[g] <= scl_pipe[g-1];
        sda_pipe[g] <= sda_pipe[g-1];
      end
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/chsel_slave_fsm.sv
module chsel_slave_fsm
  import chsel_pkg::*;
#(
  parameter int KEEP_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_p,
  input  logic                stop_p,
  input  logic                sda_s,
  input  logic [ADDR_W-1:0]   dev_addr,
  input  logic [BYTE_W-1:0]   rd_byte,
  output logic                wr_en,
  output logic [KEEP_W-1:0]   wr_data,
  output logic                sda_oe,
  output slv_state_t          state_o
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  slv_state_t          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [ADDR_W-1:0]   shreg_q;
  logic [BYTE_W-1:0]   tx_q;
  logic                rw_q;

  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_p) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_p) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: if (scl_rise) begin
            shreg_q <= {shreg_q[ADDR_W-2:0], sda_s};
            if (cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              if (shreg_q == dev_addr) begin
                rw_q    <= sda_s;
                state_q <= ST_ACK_WAIT;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            sda_oe  <= 1'b1;
            state_q <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_byte;
              sda_oe  <= ~rd_byte[BYTE_W-1];
              state_q <= ST_RD;
            end else begin
              sda_oe  <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_WR: if (scl_rise) begin
            shreg_q <= {shreg_q[ADDR_W-2:0], sda_s};
            if (cnt_q == LAST_BIT) begin
              cnt_q   <= '0;
              wr_en   <= 1'b1;
              wr_data <= {shreg_q[KEEP_W-2:0], sda_s};
              state_q <= ST_ACK_WAIT;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              if (cnt_q == LAST_BIT) begin
                cnt_q   <= '0;
                state_q <= ST_RD_ACK_WAIT;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end else if (scl_fall) begin
              tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_q[BYTE_W-2];
            end
          end
          ST_RD_ACK_WAIT: if (scl_fall) begin
            sda_oe  <= 1'b0;
            state_q <= ST_RD_ACK;
          end
          ST_RD_ACK: if (scl_rise) begin
            state_q <= sda_s ? ST_IDLE : ST_RD_LOAD;
          end
          ST_RD_LOAD: if (scl_fall) begin
            tx_q    <= rd_byte;
            sda_oe  <= ~rd_byte[BYTE_W-1];
            cnt_q   <= '0;
            state_q <= ST_RD;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/chsel_ctrl_reg.sv
module chsel_ctrl_reg
  import chsel_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [N_CH-1:0]   wr_sel,
  input  logic              stop_p,
  input  logic [N_CH-1:0]   irq_pend,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [N_CH-1:0]   chan_en
);

  logic [N_CH-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      chan_en <= '0;
    end else begin
      if (wr_en) sel_q <= wr_sel;
      if (stop_p) chan_en <= sel_q;
    end
  end

  always_comb begin
    rd_byte = '0;
    rd_byte[N_CH-1:0] = sel_q;
    rd_byte[IRQ_LSB +: N_CH] = irq_pend;
  end

endmodule

// File: rtl/chsel_i2c_ctrl.sv
module chsel_i2c_ctrl
  import chsel_pkg::*;
#(
  parameter int ADDR_VARIANT = 0,
  parameter int SYNC_STAGES  = 2,
  parameter int N_CH         = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic [1:0]      addr_strap,
  input  logic [N_CH-1:0] irq_pend,
  output logic [N_CH-1:0] chan_en,
  output logic            sda_oe
);

  localparam logic [4:0] PREFIX = addr_prefix(ADDR_VARIANT);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_p;
  logic              stop_p;
  logic              wr_en;
  logic [N_CH-1:0]   wr_sel;
  logic [BYTE_W-1:0] rd_byte;
  slv_state_t        state_q;
  logic [ADDR_W-1:0] dev_addr;

  assign dev_addr = {PREFIX, addr_strap};

  chsel_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  chsel_slave_fsm #(.KEEP_W(N_CH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .sda_s(sda_s),
    .dev_addr(dev_addr), .rd_byte(rd_byte), .wr_en(wr_en),
    .wr_data(wr_sel), .sda_oe(sda_oe), .state_o(state_q)
  );

  chsel_ctrl_reg #(.N_CH(N_CH)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .stop_p(stop_p), .irq_pend(irq_pend), .rd_byte(rd_byte),
    .chan_en(chan_en)
  );

endmodule

// File: rtl/chsel_i2c_ctrl_chk.sv
module chsel_i2c_ctrl_chk
  import chsel_pkg::*;
#(
  parameter int N_CH = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_in,
  input logic [N_CH-1:0] chan_en,
  input logic            sda_oe,
  input logic            stop_p,
  input slv_state_t      state_q
);

  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst_n;
    if (rst_q === 1'b0) begin
      p_reset_clear_r1: assert (chan_en == '0 && !sda_oe)
        else $error("R1: outputs not cleared after reset");
    end
  end

  // R2: an unaddressed engine never drives the line
  p_idle_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe);

  // R4: channel outputs move only after a STOP
  p_chan_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en != $past(chan_en)) |-> $past(stop_p));

  // R8: a STOP always leaves SDA released
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_oe);

  // R11: drive changes happen only in the SCL low phase
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_in);

endmodule

bind chsel_i2c_ctrl chsel_i2c_ctrl_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .chan_en(chan_en),
  .sda_oe(sda_oe), .stop_p(stop_p), .state_q(state_q)
);

// File: tb/chsel_i2c_ctrl_bench.sv
`timescale 1ns/1ps
module chsel_i2c_ctrl_bench;

  localparam logic [6:0] MY_ADDR = 7'b1110010;  // prefix 11100, strap 10
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] irq = 2'b00;
  logic [1:0] chan_en;
  logic       sda_oe;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;

  logic [1:0] model_sel  = 2'b00;
  logic [1:0] model_chan = 2'b00;
  logic [1:0] hist [0:LAT];

  always #2.5 clk = ~clk;

  chsel_i2c_ctrl u_chsel_i2c_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_strap(2'b10), .irq_pend(irq), .chan_en(chan_en), .sda_oe(sda_oe)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference for chan_en, delayed by the synchronizer and edge detect (R4)
  always @(negedge clk) begin
    #1;
    if (!cmp_en) begin
      for (int i = 0; i <= LAT; i++) hist[i] = model_chan;
    end else begin
      for (int i = LAT; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = model_chan;
      chk("R4 chan_en vs model", chan_en, hist[LAT]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_n(5);
    scl_m = 1'b1; wait_n(10);
    sda_m = 1'b0; wait_n(10);
    scl_m = 1'b0; wait_n(5);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wait_n(5);
    scl_m = 1'b1; wait_n(10);
    sda_m = 1'b1; model_chan = model_sel;
    wait_n(20);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_n(5);
    scl_m = 1'b1; wait_n(10);
    scl_m = 1'b0; wait_n(5);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_n(5);
    scl_m = 1'b1; wait_n(5);
    b = sda_line; wait_n(5);
    scl_m = 1'b0; wait_n(5);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] d, input logic master_ack);
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      d = {d[6:0], b};
    end
    put_bit(master_ack);
  endtask

  task automatic write_txn(input logic [7:0] d, input string req);
    logic ack;
    do_start();
    put_byte({MY_ADDR, 1'b0}, ack);
    chk({req, " addr ack"}, ack, 0);
    put_byte(d, ack);
    chk({req, " data ack"}, ack, 0);
    model_sel = d[1:0];
    chk("R4 chan_en before STOP", chan_en, model_chan);
    do_stop();
  endtask

  task automatic read_one(input logic [7:0] exp, input string req);
    logic ack;
    logic [7:0] d;
    do_start();
    put_byte({MY_ADDR, 1'b1}, ack);
    chk({req, " read addr ack"}, ack, 0);
    get_byte(d, 1'b1);
    chk(req, d, exp);
    chk("R8 SDA released after NACK", sda_line, 1);
    do_stop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    wait_n(6);
    chk("R1 chan_en in reset", chan_en, 0);
    chk("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    wait_n(5);
    read_one(8'h00, "R1 register after reset");

    // R6: upper write bits discarded; irq in bits 5:4
    write_txn(8'hFD, "R3");
    irq = 2'b10;
    read_one(8'h21, "R6 read format irq1 sel01");

    // R3/R5: multi-byte write keeps last, both channels
    do_start();
    put_byte({MY_ADDR, 1'b0}, ack); chk("R3 addr ack", ack, 0);
    put_byte(8'h02, ack); chk("R3 byte1 ack", ack, 0);
    put_byte(8'hFE, ack); chk("R3 byte2 ack", ack, 0);
    put_byte(8'h03, ack); chk("R3 byte3 ack", ack, 0);
    model_sel = 2'b11;
    chk("R4 chan_en held before STOP", chan_en, 2'b01);
    do_stop();
    chk("R5 both channels", chan_en, 2'b11);
    irq = 2'b00;
    read_one(8'h03, "R3 last byte kept");

    write_txn(8'h00, "R5");
    chk("R5 no channel", chan_en, 2'b00);

    // R2: wrong strap and wrong prefix are ignored
    do_start();
    put_byte({7'b1110001, 1'b0}, ack);
    chk("R2 no ack wrong strap", ack, 1);
    put_byte(8'h03, ack);
    chk("R2 no ack data after mismatch", ack, 1);
    do_stop();
    do_start();
    put_byte({7'b0110010, 1'b0}, ack);
    chk("R2 no ack wrong prefix", ack, 1);
    do_stop();
    chk("R2 chan_en untouched", chan_en, 2'b00);
    read_one(8'h00, "R2 register untouched");

    // R7: interrupt bits frozen at byte load
    write_txn(8'h01, "R7 setup");
    irq = 2'b01;
    do_start();
    put_byte({MY_ADDR, 1'b1}, ack); chk("R7 addr ack", ack, 0);
    get_byte(d, 1'b0);
    chk("R7 first byte", d, 8'h11);
    irq = 2'b10;
    get_byte(d, 1'b0);
    chk("R7 second byte keeps loaded irq", d, 8'h11);
    get_byte(d, 1'b1);
    chk("R8 third byte after ACK", d, 8'h21);
    chk("R8 released after NACK", sda_line, 1);
    do_stop();
    irq = 2'b00;

    // R9: repeated START discards a partial address
    do_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    do_start();
    put_byte({MY_ADDR, 1'b0}, ack); chk("R9 addr ack after restart", ack, 0);
    put_byte(8'h02, ack); chk("R9 data ack", ack, 0);
    model_sel = 2'b10;
    do_stop();
    chk("R9 chan after restart write", chan_en, 2'b10);

    // R4/R9: write, repeated START, read shows register while chan pending
    do_start();
    put_byte({MY_ADDR, 1'b0}, ack); chk("R4 addr ack", ack, 0);
    put_byte(8'h01, ack); chk("R4 data ack", ack, 0);
    model_sel = 2'b01;
    do_start();
    put_byte({MY_ADDR, 1'b1}, ack); chk("R9 read addr ack", ack, 0);
    get_byte(d, 1'b1);
    chk("R9 read after repeated START", d, 8'h01);
    chk("R4 chan_en pending across restart", chan_en, 2'b10);
    do_stop();
    chk("R4 chan_en after STOP", chan_en, 2'b01);

    // R10: reset mid-transaction
    do_start();
    put_byte({MY_ADDR, 1'b0}, ack); chk("R10 addr ack", ack, 0);
    put_byte(8'h03, ack); chk("R10 data ack", ack, 0);
    cmp_en = 1'b0;
    rst_n = 1'b0;
    model_sel = 2'b00;
    model_chan = 2'b00;
    wait_n(3);
    scl_m = 1'b1; sda_m = 1'b1;
    wait_n(3);
    chk("R10 chan_en cleared", chan_en, 0);
    chk("R10 sda_oe cleared", sda_oe, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    wait_n(5);
    read_one(8'h00, "R10 pending selection dropped");
    chk("R10 chan_en after read", chan_en, 0);

    wait_n(10);
    finish_run();
  end

endmodule